// File: doc/BRIEF.md
# Sparse Cartesian-Product Convolution Processing Element

This block is the arithmetic core of one processing element in a sparse convolution accelerator. Only non-zero operands reach it. On each transfer it takes a vector of up to F filter weights and a vector of up to I input activations. Each weight is tagged with an input channel, a horizontal tap r, a vertical tap s and an output channel k. Each activation is tagged with an input channel and a position (x, y) in the tile. The block multiplies every weight by every activation in a single F×I array.

For each product it works out the output position (x − r, y − s, k) and adds the product into an on-chip accumulator entry at that position. A product is dropped when its input channels differ or when its output position falls off the low edge of the tile.

The accumulator is split into 2·F·I banks. The bank index is the low bits of the entry address. When several products of one vector map to the same bank, the adds to that bank are done one per cycle and the input stalls until all of them are done, so no update is lost.

Activations are meant to stay resident while weight vectors stream past them. A clear input empties the accumulator before a new tile. A drain request streams every entry out in address order.

Top module: `pe_sparse_cp`

## Requirements
- R1: Every weight lane is multiplied by every activation lane as signed 8-bit values. Each product whose lanes are valid, whose channels match and whose output position is in range is added into a 24-bit two's-complement accumulator entry.
- R2: The output position is ox = x − r, oy = y − s, with output channel k. It maps to entry address (k·TH + oy)·TW + ox.
- R3: A product is discarded with no effect when x < r or y < s.
- R4: A weight or activation lane whose per-lane valid bit is 0 contributes nothing, whatever its value and tags.
- R5: A product whose weight channel differs from its activation channel contributes nothing.
- R6: The bank of a product is its address modulo 2·F·I. Each bank takes at most one add per cycle. Same-bank products of one vector are added on successive cycles in ascending lane order (lane = f·I + i), and none is lost.
- R7: A vector pair transfers on a clock edge where w_valid_i, a_valid_i and the ready outputs are all high. Each ready output equals the internal ready ANDed with the other side's valid. The internal ready is low during clr_i, during drain_i, while a drain runs, and whenever adds other than those of the current cycle are still owed. So a vector whose n products all hit one bank holds the ready outputs low for n − 1 cycles.
- R8: A cycle with clr_i high sets every accumulator entry to zero.
- R9: A drain_i pulse while no adds are owed starts a drain. On successive cycles it yields one beat per entry with rd_valid_o high. The first beat comes two edges after the request edge. rd_addr_o runs 0, 1, … DEPTH−1, rd_data_o carries that entry's value, and rd_last_o is high on the final beat only.
- R10: After reset all entries read as zero, rd_valid_o and rd_last_o are low, and the ready outputs are high when both valids are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| w_valid_i | input | 1 | Weight vector valid |
| w_ready_o | output | 1 | Weight vector ready |
| w_lane_vld_i | input | F | Per-lane weight valid bits |
| w_val_i | input | F·8 | Signed weight values, lane f at bits [8f+7:8f] |
| w_r_i | input | F·clog2(R) | Horizontal tap per weight lane |
| w_s_i | input | F·clog2(R) | Vertical tap per weight lane |
| w_k_i | input | F·clog2(K) | Output channel per weight lane |
| w_c_i | input | F·clog2(NCH) | Input channel per weight lane |
| a_valid_i | input | 1 | Activation vector valid |
| a_ready_o | output | 1 | Activation vector ready |
| a_lane_vld_i | input | I | Per-lane activation valid bits |
| a_val_i | input | I·8 | Signed activation values |
| a_x_i | input | I·clog2(TW) | Column per activation lane |
| a_y_i | input | I·clog2(TH) | Row per activation lane |
| a_c_i | input | I·clog2(NCH) | Input channel per activation lane |
| clr_i | input | 1 | Zero all accumulator entries |
| drain_i | input | 1 | Start sequential readout |
| rd_valid_o | output | 1 | Readout beat valid |
| rd_last_o | output | 1 | Final readout beat |
| rd_addr_o | output | clog2(DEPTH) | Entry address of the beat |
| rd_data_o | output | 24 | Entry value of the beat |

## Verification
The bench builds the block at its default parameters: F = I = 4, an 8×8 tile, four input and four output channels, and 3×3 taps. That gives 256 entries in 32 banks of eight. At this size every drain compares the whole accumulator against a dense convolution computed in the bench, and the zero-padded reference covers every tile edge where products fall off. The same size lets a single vector aim all 16 products at one entry, which exercises the longest possible stall and the in-order serialization. Random tiles at light and heavy density mix channels inside one vector, so channel filtering and partial final vectors are exercised together.

// File: rtl/pe_cp_pkg.sv
package pe_cp_pkg;
  localparam int unsigned PE_F   = 4;
  localparam int unsigned PE_I   = 4;
  localparam int unsigned PE_DW  = 8;
  localparam int unsigned PE_AW  = 24;
  localparam int unsigned PE_TW  = 8;
  localparam int unsigned PE_TH  = 8;
  localparam int unsigned PE_K   = 4;
  localparam int unsigned PE_NCH = 4;
  localparam int unsigned PE_R   = 3;

  typedef enum logic {DR_IDLE = 1'b0, DR_RUN = 1'b1} drain_st_e;
endpackage

// File: rtl/cp_mult_array.sv
module cp_mult_array #(
  parameter int unsigned F   = 4,
  parameter int unsigned I   = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 24,
  parameter int unsigned RW  = 2,
  parameter int unsigned XW  = 3,
  parameter int unsigned YW  = 3,
  parameter int unsigned KW  = 2,
  parameter int unsigned CHW = 2,
  parameter int unsigned ABW = 8
) (
  input  logic [F-1:0]              w_vld_i,
  input  logic [F*DW-1:0]           w_val_i,
  input  logic [F*RW-1:0]           w_r_i,
  input  logic [F*RW-1:0]           w_s_i,
  input  logic [F*KW-1:0]           w_k_i,
  input  logic [F*CHW-1:0]          w_c_i,
  input  logic [I-1:0]              a_vld_i,
  input  logic [I*DW-1:0]           a_val_i,
  input  logic [I*XW-1:0]           a_x_i,
  input  logic [I*YW-1:0]           a_y_i,
  input  logic [I*CHW-1:0]          a_c_i,
  output logic [F*I-1:0]            lane_ok_o,
  output logic [F*I-1:0][ABW-1:0]   lane_addr_o,
  output logic [F*I-1:0][AW-1:0]    lane_prod_o
);
  for (genvar f = 0; f < F; f++) begin : g_w
    for (genvar i = 0; i < I; i++) begin : g_a
      localparam int unsigned L = f * I + i;
      logic signed [DW-1:0]   wv, av;
      logic signed [2*DW-1:0] p;
      logic [XW:0] xd;
      logic [YW:0] yd;
      assign wv = w_val_i[f*DW +: DW];
      assign av = a_val_i[i*DW +: DW];
      assign p  = wv * av;
      // borrow bit set means the output lands left of / above the tile
      assign xd = {1'b0, a_x_i[i*XW +: XW]} - (XW+1)'(w_r_i[f*RW +: RW]);
      assign yd = {1'b0, a_y_i[i*YW +: YW]} - (YW+1)'(w_s_i[f*RW +: RW]);
      assign lane_ok_o[L] = w_vld_i[f] & a_vld_i[i] & ~xd[XW] & ~yd[YW]
                          & (w_c_i[f*CHW +: CHW] == a_c_i[i*CHW +: CHW]);
      assign lane_addr_o[L] = {w_k_i[f*KW +: KW], yd[YW-1:0], xd[XW-1:0]};
      assign lane_prod_o[L] = {{(AW-2*DW){p[2*DW-1]}}, p};
    end
  end
endmodule

// File: rtl/cp_bank_arb.sv
module cp_bank_arb #(
  parameter int unsigned L   = 16,
  parameter int unsigned ABW = 8,
  parameter int unsigned BBW = 5
) (
  input  logic [L-1:0]           req_i,
  input  logic [L-1:0][ABW-1:0]  addr_i,
  output logic [L-1:0]           gnt_o
);
  // lowest lane wins each bank
  always_comb begin
    gnt_o = req_i;
    for (int l = 1; l < L; l++) begin
      for (int j = 0; j < l; j++) begin
        if (req_i[j] && (addr_i[j][BBW-1:0] == addr_i[l][BBW-1:0])) gnt_o[l] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cp_acc_banks.sv
module cp_acc_banks #(
  parameter int unsigned L   = 16,
  parameter int unsigned AW  = 24,
  parameter int unsigned ABW = 8,
  parameter int unsigned BBW = 5,
  parameter int unsigned NB  = 32,
  parameter int unsigned BD  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic [L-1:0]           gnt_i,
  input  logic [L-1:0][ABW-1:0]  addr_i,
  input  logic [L-1:0][AW-1:0]   prod_i,
  input  logic                   rd_en_i,
  input  logic [ABW-1:0]         rd_addr_i,
  output logic [AW-1:0]          rd_data_o
);
  logic [AW-1:0] mem [NB][BD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++)
        for (int d = 0; d < BD; d++) mem[b][d] <= '0;
      rd_data_o <= '0;
    end else begin
      if (clr_i) begin
        for (int b = 0; b < NB; b++)
          for (int d = 0; d < BD; d++) mem[b][d] <= '0;
      end else begin
        // grants are bank-exclusive: one adder per lane, one write per bank
        for (int l = 0; l < L; l++) begin
          if (gnt_i[l])
            mem[addr_i[l][BBW-1:0]][addr_i[l][ABW-1:BBW]] <=
              mem[addr_i[l][BBW-1:0]][addr_i[l][ABW-1:BBW]] + prod_i[l];
        end
      end
      if (rd_en_i) rd_data_o <= mem[rd_addr_i[BBW-1:0]][rd_addr_i[ABW-1:BBW]];
    end
  end
endmodule

// File: rtl/pe_sparse_cp.sv
module pe_sparse_cp
  import pe_cp_pkg::*;
#(
  parameter int unsigned F   = PE_F,
  parameter int unsigned I   = PE_I,
  parameter int unsigned DW  = PE_DW,
  parameter int unsigned AW  = PE_AW,
  parameter int unsigned TW  = PE_TW,
  parameter int unsigned TH  = PE_TH,
  parameter int unsigned K   = PE_K,
  parameter int unsigned NCH = PE_NCH,
  parameter int unsigned R   = PE_R,
  localparam int unsigned L     = F * I,
  localparam int unsigned XW    = $clog2(TW),
  localparam int unsigned YW    = $clog2(TH),
  localparam int unsigned KW    = $clog2(K),
  localparam int unsigned CHW   = $clog2(NCH),
  localparam int unsigned RW    = $clog2(R),
  localparam int unsigned ABW   = KW + YW + XW,
  localparam int unsigned DEPTH = TW * TH * K,
  localparam int unsigned NB    = 2 * L,
  localparam int unsigned BBW   = $clog2(NB),
  localparam int unsigned BD    = DEPTH / NB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               w_valid_i,
  output logic               w_ready_o,
  input  logic [F-1:0]       w_lane_vld_i,
  input  logic [F*DW-1:0]    w_val_i,
  input  logic [F*RW-1:0]    w_r_i,
  input  logic [F*RW-1:0]    w_s_i,
  input  logic [F*KW-1:0]    w_k_i,
  input  logic [F*CHW-1:0]   w_c_i,
  input  logic               a_valid_i,
  output logic               a_ready_o,
  input  logic [I-1:0]       a_lane_vld_i,
  input  logic [I*DW-1:0]    a_val_i,
  input  logic [I*XW-1:0]    a_x_i,
  input  logic [I*YW-1:0]    a_y_i,
  input  logic [I*CHW-1:0]   a_c_i,
  input  logic               clr_i,
  input  logic               drain_i,
  output logic               rd_valid_o,
  output logic               rd_last_o,
  output logic [ABW-1:0]     rd_addr_o,
  output logic [AW-1:0]      rd_data_o
);
  logic [F-1:0]     w_vld_q;
  logic [F*DW-1:0]  w_val_q;
  logic [F*RW-1:0]  w_r_q, w_s_q;
  logic [F*KW-1:0]  w_k_q;
  logic [F*CHW-1:0] w_c_q;
  logic [I-1:0]     a_vld_q;
  logic [I*DW-1:0]  a_val_q;
  logic [I*XW-1:0]  a_x_q;
  logic [I*YW-1:0]  a_y_q;
  logic [I*CHW-1:0] a_c_q;
  logic [L-1:0]     pend_q;

  logic [L-1:0]           lane_ok, req, gnt_raw, gnt;
  logic [L-1:0][ABW-1:0]  lane_addr;
  logic [L-1:0][AW-1:0]   lane_prod;
  logic                   in_ready, accept, drain_busy;
  drain_st_e              dr_st;
  logic [ABW-1:0]         drain_cnt;

  cp_mult_array #(
    .F(F), .I(I), .DW(DW), .AW(AW), .RW(RW), .XW(XW), .YW(YW),
    .KW(KW), .CHW(CHW), .ABW(ABW)
  ) u_mul (
    .w_vld_i(w_vld_q), .w_val_i(w_val_q), .w_r_i(w_r_q), .w_s_i(w_s_q),
    .w_k_i(w_k_q), .w_c_i(w_c_q),
    .a_vld_i(a_vld_q), .a_val_i(a_val_q), .a_x_i(a_x_q), .a_y_i(a_y_q),
    .a_c_i(a_c_q),
    .lane_ok_o(lane_ok), .lane_addr_o(lane_addr), .lane_prod_o(lane_prod)
  );

  assign req = pend_q & lane_ok;

  cp_bank_arb #(.L(L), .ABW(ABW), .BBW(BBW)) u_arb (
    .req_i(req), .addr_i(lane_addr), .gnt_o(gnt_raw)
  );

  assign gnt        = clr_i ? '0 : gnt_raw;
  assign drain_busy = (dr_st == DR_RUN);
  assign in_ready   = !clr_i && !drain_i && !drain_busy && ((req & ~gnt) == '0);
  assign w_ready_o  = in_ready & a_valid_i;
  assign a_ready_o  = in_ready & w_valid_i;
  assign accept     = in_ready & w_valid_i & a_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_vld_q <= '0; w_val_q <= '0; w_r_q <= '0; w_s_q <= '0;
      w_k_q   <= '0; w_c_q   <= '0;
      a_vld_q <= '0; a_val_q <= '0; a_x_q <= '0; a_y_q <= '0; a_c_q <= '0;
      pend_q  <= '0;
    end else if (accept) begin
      w_vld_q <= w_lane_vld_i; w_val_q <= w_val_i; w_r_q <= w_r_i;
      w_s_q   <= w_s_i;        w_k_q   <= w_k_i;   w_c_q <= w_c_i;
      a_vld_q <= a_lane_vld_i; a_val_q <= a_val_i; a_x_q <= a_x_i;
      a_y_q   <= a_y_i;        a_c_q   <= a_c_i;
      pend_q  <= '1;
    end else begin
      pend_q  <= pend_q & ~gnt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_st      <= DR_IDLE;
      drain_cnt  <= '0;
      rd_valid_o <= 1'b0;
      rd_last_o  <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      case (dr_st)
        DR_IDLE: begin
          rd_valid_o <= 1'b0;
          rd_last_o  <= 1'b0;
          if (drain_i && !clr_i && (req == '0)) begin
            dr_st     <= DR_RUN;
            drain_cnt <= '0;
          end
        end
        default: begin
          rd_valid_o <= 1'b1;
          rd_addr_o  <= drain_cnt;
          rd_last_o  <= (drain_cnt == ABW'(DEPTH - 1));
          drain_cnt  <= drain_cnt + 1'b1;
          if (drain_cnt == ABW'(DEPTH - 1)) dr_st <= DR_IDLE;
        end
      endcase
    end
  end

  cp_acc_banks #(
    .L(L), .AW(AW), .ABW(ABW), .BBW(BBW), .NB(NB), .BD(BD)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .gnt_i(gnt), .addr_i(lane_addr), .prod_i(lane_prod),
    .rd_en_i(drain_busy), .rd_addr_i(drain_cnt), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/pe_sparse_cp_chk.sv
module pe_sparse_cp_chk #(
  parameter int unsigned L   = 16,
  parameter int unsigned ABW = 8,
  parameter int unsigned BBW = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [L-1:0]           req,
  input logic [L-1:0]           gnt,
  input logic [L-1:0][ABW-1:0]  lane_addr,
  input logic                   in_ready,
  input logic                   drain_busy,
  input logic                   rd_valid_o,
  input logic                   rd_last_o,
  input logic [ABW-1:0]         rd_addr_o
);
  for (genvar a = 0; a < L; a++) begin : g_la
    // R6: an owed add stays owed until granted
    p_no_loss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req[a] && !gnt[a] |=> req[a]);
    for (genvar b = a + 1; b < L; b++) begin : g_lb
      // R6: one add per bank per cycle
      p_bank_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt[a] && gnt[b] |-> lane_addr[a][BBW-1:0] != lane_addr[b][BBW-1:0]);
    end
  end

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req & ~gnt) != '0) |-> !in_ready);

  p_drain_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_busy |-> !in_ready);

  p_rd_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> rd_addr_o == '0);

  p_rd_seq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && $past(rd_valid_o) |-> rd_addr_o == ABW'($past(rd_addr_o) + 1'b1));

  p_rd_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o && (rd_addr_o == '1));
endmodule

bind pe_sparse_cp pe_sparse_cp_chk #(.L(L), .ABW(ABW), .BBW(BBW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req(req), .gnt(gnt), .lane_addr(lane_addr),
  .in_ready(in_ready), .drain_busy(drain_busy), .rd_valid_o(rd_valid_o),
  .rd_last_o(rd_last_o), .rd_addr_o(rd_addr_o)
);

// File: tb/tb_pe_sparse_cp.sv
`timescale 1ns/1ps
module tb_pe_sparse_cp;
  localparam int F = 4, I = 4, DW = 8, AW = 24;
  localparam int TW = 8, TH = 8, K = 4, NCH = 4, R = 3;
  localparam int XW = 3, YW = 3, KW = 2, CHW = 2, RW = 2, ABW = 8;
  localparam int DEPTH = TW * TH * K;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic w_valid = 0, a_valid = 0, clr = 0, drain = 0;
  logic [F-1:0] w_lv = '0;
  logic [I-1:0] a_lv = '0;
  logic [F*DW-1:0] w_val = '0;
  logic [F*RW-1:0] w_r = '0, w_s = '0;
  logic [F*KW-1:0] w_k = '0;
  logic [F*CHW-1:0] w_c = '0;
  logic [I*DW-1:0] a_val = '0;
  logic [I*XW-1:0] a_x = '0;
  logic [I*YW-1:0] a_y = '0;
  logic [I*CHW-1:0] a_c = '0;
  logic w_ready, a_ready, rd_valid, rd_last;
  logic [ABW-1:0] rd_addr;
  logic [AW-1:0] rd_data;

  pe_sparse_cp dut (
    .clk_i(clk), .rst_ni(rst_n),
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_lane_vld_i(w_lv),
    .w_val_i(w_val), .w_r_i(w_r), .w_s_i(w_s), .w_k_i(w_k), .w_c_i(w_c),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_lane_vld_i(a_lv),
    .a_val_i(a_val), .a_x_i(a_x), .a_y_i(a_y), .a_c_i(a_c),
    .clr_i(clr), .drain_i(drain),
    .rd_valid_o(rd_valid), .rd_last_o(rd_last), .rd_addr_o(rd_addr), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_bad = 0;
  int exp_mem [DEPTH];
  int ad [NCH][TH][TW];
  int wd [K][NCH][R][R];
  int al_v [256], al_x [256], al_y [256], al_c [256];
  int wl_v [256], wl_r [256], wl_s [256], wl_k [256], wl_c [256];
  int na, nw;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic set_w(int f, int v, int r, int s, int k, int c, bit vld);
    w_val[f*DW +: DW] = DW'(v); w_r[f*RW +: RW] = RW'(r); w_s[f*RW +: RW] = RW'(s);
    w_k[f*KW +: KW] = KW'(k); w_c[f*CHW +: CHW] = CHW'(c); w_lv[f] = vld;
  endtask

  task automatic set_a(int i, int v, int x, int y, int c, bit vld);
    a_val[i*DW +: DW] = DW'(v); a_x[i*XW +: XW] = XW'(x); a_y[i*YW +: YW] = YW'(y);
    a_c[i*CHW +: CHW] = CHW'(c); a_lv[i] = vld;
  endtask

  // called at a negedge; returns the number of cycles ready stayed low
  task automatic xfer(output int stall);
    w_valid = 1; a_valid = 1; stall = 0; #1;
    while (!a_ready) begin @(negedge clk); #1; stall++; end
    @(negedge clk);
    w_valid = 0; a_valid = 0;
  endtask

  task automatic do_clear();
    clr = 1; @(negedge clk); clr = 0;
    for (int e = 0; e < DEPTH; e++) exp_mem[e] = 0;
  endtask

  task automatic drain_check(string req);
    repeat (20) @(negedge clk);
    drain = 1; @(negedge clk); drain = 0;
    for (int e = 0; e < DEPTH; e++) begin
      int wdg = 0;
      while (!rd_valid && wdg < 50) begin @(negedge clk); wdg++; end
      if (!(rd_valid && rd_addr == ABW'(e) && rd_last == (e == DEPTH - 1)))
        chk(0, "R9 beat order", int'(rd_addr), e);
      else
        chk(int'($signed(rd_data)) == exp_mem[e], req, int'($signed(rd_data)), exp_mem[e]);
      @(negedge clk);
    end
    chk(!rd_valid, "R9 end of drain", int'(rd_valid), 0);
  endtask

  task automatic rnd_tile(int pct);
    int st;
    for (int c = 0; c < NCH; c++) for (int y = 0; y < TH; y++) for (int x = 0; x < TW; x++) begin
      ad[c][y][x] = 0;
      if ($urandom_range(99) < pct) begin
        ad[c][y][x] = int'($urandom_range(255)) - 128;
        if (ad[c][y][x] == 0) ad[c][y][x] = 1;
      end
    end
    for (int k = 0; k < K; k++) for (int c = 0; c < NCH; c++)
      for (int r = 0; r < R; r++) for (int s = 0; s < R; s++) begin
        wd[k][c][r][s] = 0;
        if ($urandom_range(99) < pct) begin
          wd[k][c][r][s] = int'($urandom_range(255)) - 128;
          if (wd[k][c][r][s] == 0) wd[k][c][r][s] = -1;
        end
      end
    // dense reference: R1, R2, R3 by construction of the sum bounds
    for (int k = 0; k < K; k++) for (int oy = 0; oy < TH; oy++) for (int ox = 0; ox < TW; ox++) begin
      int acc = 0;
      for (int c = 0; c < NCH; c++) for (int r = 0; r < R; r++) for (int s = 0; s < R; s++)
        if (ox + r < TW && oy + s < TH) acc += wd[k][c][r][s] * ad[c][oy+s][ox+r];
      exp_mem[(k*TH + oy)*TW + ox] = acc;
    end
    na = 0; nw = 0;
    for (int c = 0; c < NCH; c++) for (int y = 0; y < TH; y++) for (int x = 0; x < TW; x++)
      if (ad[c][y][x] != 0) begin
        al_v[na] = ad[c][y][x]; al_x[na] = x; al_y[na] = y; al_c[na] = c; na++;
      end
    for (int k = 0; k < K; k++) for (int c = 0; c < NCH; c++)
      for (int r = 0; r < R; r++) for (int s = 0; s < R; s++)
        if (wd[k][c][r][s] != 0) begin
          wl_v[nw] = wd[k][c][r][s]; wl_r[nw] = r; wl_s[nw] = s;
          wl_k[nw] = k; wl_c[nw] = c; nw++;
        end
    // activations held while all weight vectors stream (partial tails use lane valids, R4)
    for (int ag = 0; ag < na; ag += I) begin
      for (int i = 0; i < I; i++)
        if (ag + i < na) set_a(i, al_v[ag+i], al_x[ag+i], al_y[ag+i], al_c[ag+i], 1);
        else set_a(i, 77, 7, 7, 0, 0);
      for (int wg = 0; wg < nw; wg += F) begin
        for (int f = 0; f < F; f++)
          if (wg + f < nw) set_w(f, wl_v[wg+f], wl_r[wg+f], wl_s[wg+f], wl_k[wg+f], wl_c[wg+f], 1);
          else set_w(f, 55, 0, 0, 0, 0, 0);
        xfer(st);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st;
    for (int e = 0; e < DEPTH; e++) exp_mem[e] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!rd_valid && !rd_last, "R10 readout idle", int'(rd_valid), 0);
    a_valid = 1; #1;
    chk(w_ready == 1'b1 && a_ready == 1'b0, "R7 ready needs other valid", int'(a_ready), 0);
    w_valid = 1; #1;
    chk(w_ready && a_ready, "R10 ready after reset", int'(a_ready), 1);
    w_valid = 0; a_valid = 0;
    @(negedge clk);
    drain_check("R10 entries zero");

    // R6/R7: 16 products to one entry, then measure stall before next vector
    do_clear();
    for (int i = 0; i < I; i++) set_a(i, i + 1, 5, 6, 1, 1);
    set_w(0, 10, 1, 2, 3, 1, 1); set_w(1, -20, 1, 2, 3, 1, 1);
    set_w(2, 30, 1, 2, 3, 1, 1); set_w(3, 5, 1, 2, 3, 1, 1);
    xfer(st);
    chk(st == 0, "R7 idle accept", st, 0);
    w_lv = '0; a_lv = '0;
    xfer(st);
    chk(st == 15, "R6 R7 conflict stall cycles", st, 15);
    exp_mem[(3*TH + 4)*TW + 4] = 250;  // R2 address of (4,4,3)
    drain_check("R6 serialized sum");

    // R3/R4/R5 discards, R8 clear of previous 250
    do_clear();
    set_a(0, 7, 1, 3, 0, 1);
    set_a(1, 9, 4, 0, 0, 1);
    set_a(2, 50, 6, 6, 0, 0);
    set_a(3, 11, 6, 6, 2, 1);
    set_w(0, 3, 2, 0, 1, 0, 1);
    set_w(1, -4, 0, 1, 0, 0, 1);
    set_w(2, 100, 0, 0, 2, 0, 0);
    set_w(3, 100, 0, 0, 2, 2, 0);
    xfer(st);
    exp_mem[(0*TH + 2)*TW + 1] = -28;
    exp_mem[(1*TH + 0)*TW + 2] = 27;
    drain_check("R3 R4 R5 discards");

    // R8 clear
    do_clear();
    drain_check("R8 cleared");

    // R1 random sparse tiles
    do_clear();
    rnd_tile(40);
    drain_check("R1 tile 40pct");
    do_clear();
    rnd_tile(90);
    drain_check("R1 R2 tile 90pct");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule